// File: doc/BRIEF.md
# Filterless Dual-Channel Bridge PWM Modulator

This block turns two streams of signed digital audio samples (left and right) into pulse-width modulated drive for two bridge outputs. Each channel has two legs, P and N. Both legs idle at half duty and move in opposite directions as the sample moves away from zero. When the input is silent the two legs switch together and the load between them sees almost no differential voltage, so no reconstruction filter is needed.

A sample strobe delivers new samples at any time. The block holds the latest one and applies it only at the start of the next PWM period, so a period never carries a partial pulse. A duty ceiling acts as a virtual supply rail and is mirrored by a matching floor. A parallel mode drives all four legs from the right-channel sample so that two bridges can be tied together. Two controls turn the drive off: mute (enable low) and a high-impedance request. Either one parks every leg low and drops its output enable. The block reports the four duty counts in effect.

Top module: `pwm_bridge_mod`

## Requirements
- R1: After reset every reported duty equals 128, which is the idle half-period of a 256-clock PWM period.
- R2: Leg bit positions are 0 = left P, 1 = left N, 2 = right P, 3 = right N. While enable_i is 1 and hiz_i is 0, all four bits of leg_oe_o are 1.
- R3: A zero sample gives a P duty of 128 and an N duty of 128 for that channel. The two legs are then equal on every cycle.
- R4: Let s be the sample arithmetically shifted right by one (rounded toward minus infinity). Before limiting, P duty = 128 + s and N duty = 128 - s. A positive sample raises P above 128 and lowers N below it, and a negative sample does the reverse.
- R5: The ceiling C is taken as duty_ceil_i limited to the range 128..256. Each duty is clamped to the range 256-C .. C.
- R6: In each 256-clock period a leg with duty d is high for exactly d clocks. The pulse is centred on mid-period, so a channel's shorter pulse lies inside its longer one.
- R7: Duties change only at a period boundary, and the last strobed sample before that boundary wins. Strobes during a period leave the running period's duties unchanged.
- R8: When parallel_i is 1 at a boundary, the left sample is ignored. Both left legs take the N duty of the right sample, both right legs take its P duty, and the two legs of each channel are equal on every cycle.
- R9: While enable_i is 0, leg_o and leg_oe_o are all 0, and new samples still update the reported duties at boundaries.
- R10: While hiz_i is 1, leg_o and leg_oe_o are all 0, whatever enable_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Strobe that captures both samples |
| left_sample_i | input | SAMPLE_W | Signed left-channel sample |
| right_sample_i | input | SAMPLE_W | Signed right-channel sample |
| duty_ceil_i | input | CNT_W+1 | Duty ceiling (virtual rail) |
| parallel_i | input | 1 | Parallel-bridge mode select |
| enable_i | input | 1 | Run enable, low mutes |
| hiz_i | input | 1 | High-impedance request |
| leg_o | output | 4 | Leg drive levels |
| leg_oe_o | output | 4 | Leg output enables |
| left_duty_p_o | output | CNT_W+1 | Left P duty in effect |
| left_duty_n_o | output | CNT_W+1 | Left N duty in effect |
| right_duty_p_o | output | CNT_W+1 | Right P duty in effect |
| right_duty_n_o | output | CNT_W+1 | Right N duty in effect |

## Verification
Several properties are checked on every cycle:
- duties hold still inside a period;
- P and N duties sum to the full period outside parallel mode;
- equal duties give identical legs, including the in-phase legs of parallel mode;
- mute and the high-impedance request silence and disable every leg.

Other behaviour only the bench scenarios can show: the exact scaling and saturation against the ceiling, the high-time count per period, the nesting of centred pulses, and which of several strobes inside one period takes effect.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int unsigned NUM_LEGS = 4;
  typedef enum logic [1:0] {
    LEG_LP = 2'd0,
    LEG_LN = 2'd1,
    LEG_RP = 2'd2,
    LEG_RN = 2'd3
  } leg_e;
endpackage

// File: rtl/pbm_period_ctr.sv
module pbm_period_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;
endmodule

// File: rtl/pbm_duty_calc.sv
module pbm_duty_calc #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = 8
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [CNT_W:0]      ceil_i,
  output logic        [CNT_W:0]      p_o,
  output logic        [CNT_W:0]      n_o
);
  localparam int unsigned DW   = CNT_W + 1;
  localparam int unsigned WW   = SAMPLE_W + DW + 1;
  localparam int unsigned FULL = 1 << CNT_W;
  localparam int unsigned HALF = FULL / 2;
  localparam logic signed [WW-1:0] HALF_S = WW'(HALF);
  localparam logic signed [WW-1:0] FULL_S = WW'(FULL);

  logic        [DW-1:0] ceil_eff, floor_eff;
  logic signed [WW-1:0] ext, s, p_raw, n_raw, ceil_s, floor_s;

  always_comb begin
    if (ceil_i > DW'(FULL))      ceil_eff = DW'(FULL);
    else if (ceil_i < DW'(HALF)) ceil_eff = DW'(HALF);
    else                         ceil_eff = ceil_i;
    floor_eff = DW'(FULL) - ceil_eff;
    ceil_s  = {{(WW-DW){1'b0}}, ceil_eff};
    floor_s = FULL_S - ceil_s;
    ext     = {{(WW-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
    s       = ext >>> 1;
    p_raw   = HALF_S + s;
    n_raw   = HALF_S - s;

    if (p_raw > ceil_s)       p_o = ceil_eff;
    else if (p_raw < floor_s) p_o = floor_eff;
    else                      p_o = p_raw[DW-1:0];

    if (n_raw > ceil_s)       n_o = ceil_eff;
    else if (n_raw < floor_s) n_o = floor_eff;
    else                      n_o = n_raw[DW-1:0];
  end
endmodule

// File: rtl/pbm_leg_gen.sv
module pbm_leg_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   duty_i,
  output logic             high_o
);
  localparam int unsigned DW   = CNT_W + 1;
  localparam int unsigned HALF = (1 << CNT_W) / 2;

  logic [DW-1:0] lo, hi, cnt_x;

  // window [lo, hi) centred on mid-period, width = duty
  always_comb begin
    lo     = DW'(HALF) - (duty_i >> 1);
    hi     = lo + duty_i;
    cnt_x  = {1'b0, cnt_i};
    high_o = (cnt_x >= lo) && (cnt_x < hi);
  end
endmodule

// File: rtl/pwm_bridge_mod.sv
module pwm_bridge_mod
  import pbm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] left_sample_i,
  input  logic signed [SAMPLE_W-1:0] right_sample_i,
  input  logic        [CNT_W:0]      duty_ceil_i,
  input  logic                       parallel_i,
  input  logic                       enable_i,
  input  logic                       hiz_i,
  output logic        [3:0]          leg_o,
  output logic        [3:0]          leg_oe_o,
  output logic        [CNT_W:0]      left_duty_p_o,
  output logic        [CNT_W:0]      left_duty_n_o,
  output logic        [CNT_W:0]      right_duty_p_o,
  output logic        [CNT_W:0]      right_duty_n_o
);
  localparam int unsigned DW   = CNT_W + 1;
  localparam int unsigned FULL = 1 << CNT_W;
  localparam int unsigned HALF = FULL / 2;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic signed [SAMPLE_W-1:0] pend_l_q, pend_r_q, pend_l_d, pend_r_d;
  logic [DW-1:0] l_p, l_n, r_p, r_n;
  logic [NUM_LEGS-1:0][DW-1:0] duty_q, duty_d;
  logic          par_q;
  logic [NUM_LEGS-1:0] leg_raw;
  logic          run;

  pbm_period_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  // a strobe on the boundary edge still makes the next period
  assign pend_l_d = sample_valid_i ? left_sample_i  : pend_l_q;
  assign pend_r_d = sample_valid_i ? right_sample_i : pend_r_q;

  pbm_duty_calc #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_calc_l (
    .sample_i(pend_l_d), .ceil_i(duty_ceil_i), .p_o(l_p), .n_o(l_n)
  );
  pbm_duty_calc #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_calc_r (
    .sample_i(pend_r_d), .ceil_i(duty_ceil_i), .p_o(r_p), .n_o(r_n)
  );

  always_comb begin
    if (parallel_i) begin
      duty_d[LEG_LP] = r_n;
      duty_d[LEG_LN] = r_n;
      duty_d[LEG_RP] = r_p;
      duty_d[LEG_RN] = r_p;
    end else begin
      duty_d[LEG_LP] = l_p;
      duty_d[LEG_LN] = l_n;
      duty_d[LEG_RP] = r_p;
      duty_d[LEG_RN] = r_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
      duty_q   <= {NUM_LEGS{DW'(HALF)}};
      par_q    <= 1'b0;
    end else begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
      if (wrap) begin
        duty_q <= duty_d;
        par_q  <= parallel_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    pbm_leg_gen #(.CNT_W(CNT_W)) i_leg (
      .cnt_i (cnt),
      .duty_i(duty_q[g]),
      .high_o(leg_raw[g])
    );
  end

  assign run            = enable_i && !hiz_i;
  assign leg_o          = run ? leg_raw : '0;
  assign leg_oe_o       = {NUM_LEGS{run}};
  assign left_duty_p_o  = duty_q[LEG_LP];
  assign left_duty_n_o  = duty_q[LEG_LN];
  assign right_duty_p_o = duty_q[LEG_RP];
  assign right_duty_n_o = duty_q[LEG_RN];

  // R7
  duty_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0) |-> $stable(duty_q));

  // R4
  duty_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_q |-> (({1'b0, duty_q[LEG_LP]} + {1'b0, duty_q[LEG_LN]}) == (DW+1)'(FULL)
             && ({1'b0, duty_q[LEG_RP]} + {1'b0, duty_q[LEG_RN]}) == (DW+1)'(FULL)));

  // R3
  in_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q[LEG_LP] == duty_q[LEG_LN]) |-> (leg_raw[LEG_LP] == leg_raw[LEG_LN]));

  // R8
  par_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_q |-> (leg_raw[LEG_LP] == leg_raw[LEG_LN] && leg_raw[LEG_RP] == leg_raw[LEG_RN]));

  // R9
  mute_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (leg_o == '0 && leg_oe_o == '0));

  // R10
  hiz_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_i |-> (leg_o == '0 && leg_oe_o == '0));

  // R2
  oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !hiz_i) |-> (leg_oe_o == '1));
endmodule

// File: tb/test_pwm_bridge_mod.sv
module test_pwm_bridge_mod;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic signed [15:0] l_smp = '0, r_smp = '0;
  logic [8:0]        ceil_v = 9'd256;
  logic              par = 1'b0, en = 1'b1, hiz = 1'b0;
  logic [3:0]        leg, oe;
  logic [8:0]        lp, ln, rp, rn;
  int                checks = 0, errors = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  pwm_bridge_mod i_pwm_bridge_mod (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid),
    .left_sample_i(l_smp), .right_sample_i(r_smp), .duty_ceil_i(ceil_v),
    .parallel_i(par), .enable_i(en), .hiz_i(hiz),
    .leg_o(leg), .leg_oe_o(oe),
    .left_duty_p_o(lp), .left_duty_n_o(ln),
    .right_duty_p_o(rp), .right_duty_n_o(rn)
  );

  typedef struct packed {
    logic signed [15:0] l;
    logic signed [15:0] r;
    logic [8:0] ceil;
    logic       par;
    logic [8:0] lp, ln, rp, rn;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'sd0,     16'sd0,      9'd256, 1'b0, 9'd128, 9'd128, 9'd128, 9'd128}, // R3
    '{16'sd100,   -16'sd100,   9'd256, 1'b0, 9'd178, 9'd78,  9'd78,  9'd178}, // R4
    '{-16'sd3,    16'sd7,      9'd256, 1'b0, 9'd126, 9'd130, 9'd131, 9'd125}, // R4
    '{16'sd1000,  -16'sd1000,  9'd256, 1'b0, 9'd256, 9'd0,   9'd0,   9'd256}, // R5
    '{16'sd1000,  -16'sd1000,  9'd200, 1'b0, 9'd200, 9'd56,  9'd56,  9'd200}, // R5
    '{16'sd1000,  -16'sd1000,  9'd50,  1'b0, 9'd128, 9'd128, 9'd128, 9'd128}, // R5
    '{16'sd60,    -16'sd32768, 9'd400, 1'b0, 9'd158, 9'd98,  9'd0,   9'd256}, // R5
    '{16'sd500,   16'sd40,     9'd256, 1'b1, 9'd108, 9'd108, 9'd148, 9'd148}  // R8
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic signed [15:0] l, input logic signed [15:0] r);
    l_smp = l; r_smp = r; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts high time over one period, checks pulse nesting per channel (R6)
  task automatic measure(input string req, input int elp, input int eln, input int erp, input int ern);
    int c0 = 0, c1 = 0, c2 = 0, c3 = 0, nest = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      c0 += int'(leg[0]); c1 += int'(leg[1]); c2 += int'(leg[2]); c3 += int'(leg[3]);
      if (elp >= eln && leg[1] && !leg[0]) nest++;
      if (eln >  elp && leg[0] && !leg[1]) nest++;
      if (erp >= ern && leg[3] && !leg[2]) nest++;
      if (ern >  erp && leg[2] && !leg[3]) nest++;
    end
    chk(c0 == elp, {req, " R6 LP high count"}, c0, elp);
    chk(c1 == eln, {req, " R6 LN high count"}, c1, eln);
    chk(c2 == erp, {req, " R6 RP high count"}, c2, erp);
    chk(c3 == ern, {req, " R6 RN high count"}, c3, ern);
    chk(nest == 0, {req, " R6 centred nesting"}, nest, 0);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int mism;
    logic [8:0] a_lp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 enables on
    chk(lp == 9'd128 && ln == 9'd128 && rp == 9'd128 && rn == 9'd128, "R1 reset duties", int'(lp), 128);
    chk(oe == 4'hF, "R2 output enables", int'(oe), 15);
    mism = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (leg[0] != leg[1] || leg[2] != leg[3]) mism++;
    end
    chk(mism == 0, "R3 idle legs equal", mism, 0);

    // table walk: R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      ceil_v = VECS[v].ceil; par = VECS[v].par;
      strobe(VECS[v].l, VECS[v].r);
      wait_cyc(300);
      chk(lp == VECS[v].lp, $sformatf("vec%0d R4/R5 left P", v),  int'(lp), int'(VECS[v].lp));
      chk(ln == VECS[v].ln, $sformatf("vec%0d R4/R5 left N", v),  int'(ln), int'(VECS[v].ln));
      chk(rp == VECS[v].rp, $sformatf("vec%0d R4/R5 right P", v), int'(rp), int'(VECS[v].rp));
      chk(rn == VECS[v].rn, $sformatf("vec%0d R4/R5 right N", v), int'(rn), int'(VECS[v].rn));
      measure($sformatf("vec%0d", v), VECS[v].lp, VECS[v].ln, VECS[v].rp, VECS[v].rn);
    end
    par = 1'b0; ceil_v = 9'd256;

    // R7 load only at boundary, last strobe wins
    strobe(16'sd20, 16'sd0);
    a_lp = 9'd138;
    do @(negedge clk); while (lp != a_lp);
    wait_cyc(10);
    strobe(16'sd40, 16'sd0);
    wait_cyc(10);
    strobe(16'sd80, 16'sd0);
    mism = 0;
    for (int k = 22; k < 255; k++) begin
      @(negedge clk);
      if (lp != a_lp) mism++;
    end
    chk(mism == 0, "R7 duty held mid-period", mism, 0);
    @(negedge clk);
    chk(lp == 9'd168, "R7 last strobe at boundary", int'(lp), 168);

    // R9 mute
    en = 1'b0;
    strobe(-16'sd64, 16'sd0);
    mism = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (leg != 4'h0 || oe != 4'h0) mism++;
    end
    chk(mism == 0, "R9 muted legs off", mism, 0);
    chk(lp == 9'd96, "R9 duty updates while muted", int'(lp), 96);

    // R10 high impedance overrides enable
    en = 1'b1; hiz = 1'b1;
    mism = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (leg != 4'h0 || oe != 4'h0) mism++;
    end
    chk(mism == 0, "R10 hiz legs off", mism, 0);
    hiz = 1'b0;
    @(negedge clk);
    chk(oe == 4'hF, "R2 enables return", int'(oe), 15);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule